// File: doc/BRIEF.md
# Limited-Pointer Directory Entry Controller

This block is the home-side controller for the coherence directory entry of a single memory line. It keeps a small set of hardware sharer pointers, each a node identifier with a valid bit. It answers read requests directly while the set has room. It serializes writes: it invalidates every other copy, counts the acknowledgements that come back, and grants write ownership only after the last one arrives. While acknowledgements are outstanding, competing requests are refused.

When a read would need one pointer more than the hardware holds, the controller hands the request to a software trap interface. It then streams the recorded pointers out, one per cycle, so that software can fold them into a full sharer vector. After that the entry sits in a trap-on-write meta-state. In that state reads go to software. A write is also forwarded to software, and the controller waits until software loads the sharer vector back through a register port. It then runs the usual invalidate-and-count sequence from that vector.

Every outgoing message leaves through one registered message port, at most one per cycle. The message appears in the cycle after the request that caused it is accepted.

Top module: `dir_entry_ctrl`

## Requirements
- R1: After reset the block shows no message, `req_ready`=1, `meta_state`=0 (normal), `line_rw`=0 and `ack_err`=0.
- R2: A read (req_kind 0) from a node already recorded, or from a new node while fewer than NPTR(=5) pointers are in use, yields a read grant (msg_kind 1) to that node in the next cycle. Only a new node takes a pointer, so a repeated read never uses up a pointer.
- R3: A read from a new node while all NPTR pointers are in use yields a trap-read message (msg_kind 5) to the requester and no read grant.
- R4: After that overflow, `meta_state` is 1 (transfer in progress) and `req_ready` is 0 while one transfer message (msg_kind 7) is issued per recorded pointer, one per cycle. Then `meta_state` becomes 2 (trap-on-write), and later reads there produce trap-read messages only.
- R5: A write (req_kind 1) sends an invalidation (msg_kind 2), one per cycle, to every recorded sharer other than the requester. The number of acknowledgements awaited equals the number of invalidations sent.
- R6: A write-permission grant (msg_kind 4) to the writer is issued in the cycle after the last awaited acknowledgement (req_kind 2) is accepted, or directly when no invalidation is needed. `line_rw` then becomes 1 and `meta_state` 0.
- R7: While acknowledgements are awaited, each read or write request is answered with a NACK (msg_kind 3) to its sender.
- R8: An acknowledgement accepted while no write is pending sets `ack_err`, which stays set until reset. The acknowledgement produces no message.
- R9: In trap-on-write, a write produces a trap-write message (msg_kind 6) to the writer, and `req_ready` stays 0 until `sw_vec` is loaded. Bit n of `sw_vec` marks node n. Every marked node except the writer is then invalidated as in R5, and R6 completes the write.
- R10: While `line_rw`=1, a read from a node other than the owner invalidates the owner. After that acknowledgement the reader gets a read grant and becomes the only sharer, and `line_rw` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 0 read, 1 write, 2 acknowledgement, 3 no-op |
| req_node | input | NODE_W | Requesting node |
| req_ready | output | 1 | Request is accepted this cycle when high |
| sw_vec_valid | input | 1 | Software sharer vector load strobe |
| sw_vec | input | 2**NODE_W | Software sharer vector, bit n = node n |
| msg_valid | output | 1 | Message issued this cycle |
| msg_kind | output | 3 | 1 rd grant, 2 inval, 3 nack, 4 wr grant, 5 trap rd, 6 trap wr, 7 transfer |
| msg_node | output | NODE_W | Destination or subject node |
| meta_state | output | 2 | 0 normal, 1 transfer in progress, 2 trap-on-write |
| line_rw | output | 1 | Line held writable by one owner |
| ack_err | output | 1 | Sticky stray-acknowledgement flag |

## Verification
The write path is swept over every sharer count from one up to the pointer limit. Each count is tried with a writer inside the set and a writer outside it. This separates the count-minus-one case from the full-count case and covers the zero-invalidation immediate grant. An overflow run fills every pointer and then drives one read too many. It checks the transfer stream, trap forwarding in trap-on-write, and a software-supplied vector that contains the writer. Repeated reads from one node, a read from a non-owner of a writable line, refused requests during acknowledgement collection, and a stray acknowledgement each target one decision of the controller.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    RQ_READ  = 2'd0,
    RQ_WRITE = 2'd1,
    RQ_ACK   = 2'd2,
    RQ_NONE  = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    MS_NONE     = 3'd0,
    MS_RD_GRANT = 3'd1,
    MS_INV      = 3'd2,
    MS_NACK     = 3'd3,
    MS_WR_GRANT = 3'd4,
    MS_TRAP_RD  = 3'd5,
    MS_TRAP_WR  = 3'd6,
    MS_XFER     = 3'd7
  } msg_kind_e;

  typedef enum logic [2:0] {
    S_IDLE     = 3'd0,
    S_XFER     = 3'd1,
    S_TOW      = 3'd2,
    S_WAIT_SW  = 3'd3,
    S_INV      = 3'd4,
    S_WAIT_ACK = 3'd5
  } ctl_state_e;

  typedef enum logic [1:0] {
    PO_NONE = 2'd0,
    PO_ADD  = 2'd1,
    PO_SET1 = 2'd2,
    PO_POP  = 2'd3
  } ptr_op_e;
endpackage

// File: rtl/dir_ptr_set.sv
module dir_ptr_set
  import dir_pkg::*;
#(
  parameter int NODE_W = 4,
  parameter int NPTR   = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [1:0]                op,
  input  logic [NODE_W-1:0]         node,
  output logic                      hit,
  output logic                      full,
  output logic [$clog2(NPTR+1)-1:0] cnt,
  output logic [NODE_W-1:0]         first_node,
  output logic [(1<<NODE_W)-1:0]    share_vec
);
  localparam int NN = 1 << NODE_W;
  localparam int PW = (NPTR > 1) ? $clog2(NPTR) : 1;
  localparam int CW = $clog2(NPTR+1);

  logic [NPTR-1:0]   vld_q;
  logic [NODE_W-1:0] id_q [NPTR];
  logic [NPTR-1:0]   match;
  logic [PW-1:0]     free_idx, first_idx;

  for (genvar i = 0; i < NPTR; i++) begin : g_match
    assign match[i] = vld_q[i] && (id_q[i] == node);
  end

  assign hit  = |match;
  assign full = &vld_q;

  always_comb begin
    free_idx  = '0;
    first_idx = '0;
    cnt       = '0;
    share_vec = '0;
    for (int i = NPTR-1; i >= 0; i--) begin
      if (!vld_q[i]) free_idx  = PW'(i);
      if (vld_q[i])  first_idx = PW'(i);
    end
    for (int i = 0; i < NPTR; i++) begin
      cnt = cnt + CW'(vld_q[i]);
      if (vld_q[i]) share_vec = share_vec | ({{(NN-1){1'b0}}, 1'b1} << id_q[i]);
    end
  end

  assign first_node = id_q[first_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      for (int i = 0; i < NPTR; i++) id_q[i] <= '0;
    end else begin
      case (ptr_op_e'(op))
        PO_ADD: if (!full && !hit) begin
          vld_q[free_idx] <= 1'b1;
          id_q[free_idx]  <= node;
        end
        PO_SET1: begin
          for (int i = 0; i < NPTR; i++) vld_q[i] <= (i == 0);
          id_q[0] <= node;
        end
        PO_POP: vld_q[first_idx] <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dir_low_pick.sv
module dir_low_pick #(
  parameter int W = 16
) (
  input  logic [W-1:0]         vec,
  output logic                 found,
  output logic [$clog2(W)-1:0] idx,
  output logic [W-1:0]         rest
);
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = W-1; i >= 0; i--) begin
      if (vec[i]) begin
        idx   = ($clog2(W))'(i);
        found = 1'b1;
      end
    end
    rest = found ? (vec & ~({{(W-1){1'b0}}, 1'b1} << idx)) : vec;
  end
endmodule

// File: rtl/dir_entry_ctrl.sv
module dir_entry_ctrl
  import dir_pkg::*;
#(
  parameter int NODE_W = 4,
  parameter int NPTR   = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [1:0]             req_kind,
  input  logic [NODE_W-1:0]      req_node,
  output logic                   req_ready,
  input  logic                   sw_vec_valid,
  input  logic [(1<<NODE_W)-1:0] sw_vec,
  output logic                   msg_valid,
  output logic [2:0]             msg_kind,
  output logic [NODE_W-1:0]      msg_node,
  output logic [1:0]             meta_state,
  output logic                   line_rw,
  output logic                   ack_err
);
  localparam int NN  = 1 << NODE_W;
  localparam int CW  = $clog2(NN+1);
  localparam int PCW = $clog2(NPTR+1);

  ctl_state_e        state_q, st_d;
  logic              line_rw_q, rw_d;
  logic [NN-1:0]     inv_q, inv_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [NODE_W-1:0] pend_node_q, pn_d;
  logic              pend_wr_q, pw_d;
  logic              err_q, err_d;
  logic              mv_q, mv_d;
  msg_kind_e         mk_q, mk_d;
  logic [NODE_W-1:0] mn_q, mn_d;

  logic              req_acc;
  req_kind_e         rk;
  logic [NN-1:0]     req_oh, pend_oh;

  ptr_op_e           p_op;
  logic [NODE_W-1:0] p_node;
  logic              p_hit, p_full;
  logic [PCW-1:0]    p_cnt;
  logic [NODE_W-1:0] p_first;
  logic [NN-1:0]     p_vec;

  logic              pk_found;
  logic [NODE_W-1:0] pk_idx;
  logic [NN-1:0]     pk_rest;

  logic              start, done, fin_wr;
  logic [NN-1:0]     start_vec;
  logic [NODE_W-1:0] fin_node;

  dir_ptr_set #(.NODE_W(NODE_W), .NPTR(NPTR)) u_ptrs (
    .clk(clk), .rst(rst), .op(p_op), .node(p_node),
    .hit(p_hit), .full(p_full), .cnt(p_cnt),
    .first_node(p_first), .share_vec(p_vec)
  );

  dir_low_pick #(.W(NN)) u_pick (
    .vec(inv_q), .found(pk_found), .idx(pk_idx), .rest(pk_rest)
  );

  function automatic logic [CW-1:0] pop_count(input logic [NN-1:0] v);
    logic [CW-1:0] s;
    s = '0;
    for (int i = 0; i < NN; i++) s = s + CW'(v[i]);
    return s;
  endfunction

  assign req_ready = (state_q == S_IDLE) || (state_q == S_TOW) || (state_q == S_WAIT_ACK);
  assign req_acc   = req_valid && req_ready;
  assign rk        = req_kind_e'(req_kind);
  assign req_oh    = {{(NN-1){1'b0}}, 1'b1} << req_node;
  assign pend_oh   = {{(NN-1){1'b0}}, 1'b1} << pend_node_q;

  always_comb begin
    st_d = state_q;  rw_d = line_rw_q; inv_d = inv_q; cnt_d = cnt_q;
    pn_d = pend_node_q; pw_d = pend_wr_q; err_d = err_q;
    mv_d = 1'b0; mk_d = MS_NONE; mn_d = '0;
    p_op = PO_NONE; p_node = req_node;
    start = 1'b0; start_vec = '0;
    done = 1'b0; fin_wr = 1'b0; fin_node = req_node;

    case (state_q)
      S_IDLE: if (req_acc) begin
        case (rk)
          RQ_READ: begin
            if (p_hit) begin
              mv_d = 1'b1; mk_d = MS_RD_GRANT; mn_d = req_node;
            end else if (line_rw_q) begin
              start = 1'b1; start_vec = p_vec; pn_d = req_node; pw_d = 1'b0;
            end else if (!p_full) begin
              p_op = PO_ADD;
              mv_d = 1'b1; mk_d = MS_RD_GRANT; mn_d = req_node;
            end else begin
              mv_d = 1'b1; mk_d = MS_TRAP_RD; mn_d = req_node;
              st_d = S_XFER;
            end
          end
          RQ_WRITE: begin
            start = 1'b1; start_vec = p_vec & ~req_oh; pn_d = req_node; pw_d = 1'b1;
          end
          RQ_ACK:  err_d = 1'b1;
          default: ;
        endcase
      end
      S_XFER: begin
        if (p_cnt != '0) begin
          mv_d = 1'b1; mk_d = MS_XFER; mn_d = p_first;
          p_op = PO_POP;
        end
        if (p_cnt <= PCW'(1)) st_d = S_TOW;
      end
      S_TOW: if (req_acc) begin
        case (rk)
          RQ_READ:  begin mv_d = 1'b1; mk_d = MS_TRAP_RD; mn_d = req_node; end
          RQ_WRITE: begin
            mv_d = 1'b1; mk_d = MS_TRAP_WR; mn_d = req_node;
            pn_d = req_node; pw_d = 1'b1; st_d = S_WAIT_SW;
          end
          RQ_ACK:   err_d = 1'b1;
          default: ;
        endcase
      end
      S_WAIT_SW: if (sw_vec_valid) begin
        start = 1'b1; start_vec = sw_vec & ~pend_oh; pn_d = pend_node_q; pw_d = 1'b1;
      end
      S_INV: begin
        if (pk_found) begin
          mv_d = 1'b1; mk_d = MS_INV; mn_d = pk_idx;
        end
        inv_d = pk_rest;
        if (pk_rest == '0) st_d = S_WAIT_ACK;
      end
      S_WAIT_ACK: if (req_acc) begin
        case (rk)
          RQ_READ, RQ_WRITE: begin mv_d = 1'b1; mk_d = MS_NACK; mn_d = req_node; end
          RQ_ACK: begin
            if (cnt_q <= CW'(1)) begin
              done = 1'b1; fin_wr = pend_wr_q; fin_node = pend_node_q;
            end else begin
              cnt_d = cnt_q - CW'(1);
            end
          end
          default: ;
        endcase
      end
      default: st_d = S_IDLE;
    endcase

    if (start) begin
      cnt_d = pop_count(start_vec);
      inv_d = start_vec;
      if (start_vec == '0) begin
        done = 1'b1; fin_wr = pw_d; fin_node = pn_d;
      end else begin
        st_d = S_INV;
      end
    end

    if (done) begin
      mv_d   = 1'b1;
      mk_d   = fin_wr ? MS_WR_GRANT : MS_RD_GRANT;
      mn_d   = fin_node;
      rw_d   = fin_wr;
      p_op   = PO_SET1;
      p_node = fin_node;
      st_d   = S_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE; line_rw_q <= 1'b0; inv_q <= '0; cnt_q <= '0;
      pend_node_q <= '0; pend_wr_q <= 1'b0; err_q <= 1'b0;
      mv_q <= 1'b0; mk_q <= MS_NONE; mn_q <= '0;
    end else begin
      state_q <= st_d; line_rw_q <= rw_d; inv_q <= inv_d; cnt_q <= cnt_d;
      pend_node_q <= pn_d; pend_wr_q <= pw_d; err_q <= err_d;
      mv_q <= mv_d; mk_q <= mk_d; mn_q <= mn_d;
    end
  end

  assign msg_valid  = mv_q;
  assign msg_kind   = mk_q;
  assign msg_node   = mn_q;
  assign line_rw    = line_rw_q;
  assign ack_err    = err_q;
  assign meta_state = (state_q == S_XFER) ? 2'd1 :
                      ((state_q == S_TOW) || (state_q == S_WAIT_SW)) ? 2'd2 : 2'd0;
endmodule

// File: rtl/dir_entry_chk.sv
module dir_entry_chk
  import dir_pkg::*;
#(
  parameter int NODE_W = 4,
  parameter int NPTR   = 5
) (
  input logic                      clk,
  input logic                      rst,
  input logic [2:0]                state,
  input logic                      msg_valid,
  input logic [2:0]                msg_kind,
  input logic [NODE_W-1:0]         msg_node,
  input logic [NODE_W-1:0]         pend_node,
  input logic                      line_rw,
  input logic                      ack_err,
  input logic                      acc,
  input logic [1:0]                req_kind,
  input logic [$clog2(NPTR+1)-1:0] ptr_cnt
);
  // R7: a NACK only follows a cycle spent collecting acknowledgements
  a_r7_nack_only_pending: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_kind == MS_NACK) |-> ($past(state) == S_WAIT_ACK));

  // R5: the writer never receives its own invalidation
  a_r5_inv_skips_writer: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_kind == MS_INV) |-> (msg_node != pend_node));

  // R6: ownership appears only together with a write grant
  a_r6_rw_with_grant: assert property (@(posedge clk) disable iff (rst)
    $rose(line_rw) |-> (msg_valid && msg_kind == MS_WR_GRANT));

  // R4: leaving the transfer phase lands in trap-on-write with no pointers left
  a_r4_xfer_to_tow: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == S_XFER && state != S_XFER) |-> (state == S_TOW && ptr_cnt == '0));

  // R8: a stray acknowledgement raises the flag
  a_r8_stray_flag: assert property (@(posedge clk) disable iff (rst)
    (acc && req_kind == RQ_ACK && (state == S_IDLE || state == S_TOW)) |=> ack_err);

  // R8: the flag stays set
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    ack_err |=> ack_err);
endmodule

bind dir_entry_ctrl dir_entry_chk #(.NODE_W(NODE_W), .NPTR(NPTR)) u_chk (
  .clk(clk), .rst(rst), .state(state_q), .msg_valid(msg_valid),
  .msg_kind(msg_kind), .msg_node(msg_node), .pend_node(pend_node_q),
  .line_rw(line_rw), .ack_err(ack_err), .acc(req_acc),
  .req_kind(req_kind), .ptr_cnt(p_cnt)
);

// File: tb/dir_entry_ctrl_tb.sv
module dir_entry_ctrl_tb;
  localparam int NODE_W = 4;
  localparam int NPTR   = 5;
  localparam int NN     = 1 << NODE_W;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'd3;
  logic [NODE_W-1:0] req_node = '0;
  logic req_ready;
  logic sw_vec_valid = 1'b0;
  logic [NN-1:0] sw_vec = '0;
  logic msg_valid;
  logic [2:0] msg_kind;
  logic [NODE_W-1:0] msg_node;
  logic [1:0] meta_state;
  logic line_rw, ack_err;

  int checks = 0, errors = 0;
  int n_msg [8];
  int inv_mask, inv_cnt, xfer_mask, xfer_cnt, last_kind, last_node;

  dir_entry_ctrl #(.NODE_W(NODE_W), .NPTR(NPTR)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_node(req_node), .req_ready(req_ready), .sw_vec_valid(sw_vec_valid),
    .sw_vec(sw_vec), .msg_valid(msg_valid), .msg_kind(msg_kind),
    .msg_node(msg_node), .meta_state(meta_state), .line_rw(line_rw),
    .ack_err(ack_err)
  );

  always #10 clk = ~clk;

  // message log, taken 5 ns after each rising edge
  always @(posedge clk) begin
    #5;
    if (msg_valid) begin
      n_msg[msg_kind] = n_msg[msg_kind] + 1;
      if (msg_kind == 3'd2) begin
        inv_mask = inv_mask | (1 << msg_node); inv_cnt = inv_cnt + 1;
      end else if (msg_kind == 3'd7) begin
        xfer_mask = xfer_mask | (1 << msg_node); xfer_cnt = xfer_cnt + 1;
      end else begin
        last_kind = msg_kind; last_node = msg_node;
      end
    end
  end

  task automatic clear_log();
    for (int i = 0; i < 8; i++) n_msg[i] = 0;
    inv_mask = 0; inv_cnt = 0; xfer_mask = 0; xfer_cnt = 0;
    last_kind = 0; last_node = 0;
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(int k, int n);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_kind = 2'(k); req_node = NODE_W'(n);
    @(negedge clk);
    req_valid = 1'b0; req_kind = 2'd3;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    tick(2); rst = 1'b0;
    clear_log();
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    clear_log();
    tick(3); rst = 1'b0; tick(1);
    // R1 reset state
    chk("R1 msg_valid", msg_valid, 0);
    chk("R1 req_ready", req_ready, 1);
    chk("R1 meta_state", meta_state, 0);
    chk("R1 line_rw", line_rw, 0);
    chk("R1 ack_err", ack_err, 0);

    // R5/R6/R7 sweep: sharer count 1..NPTR, writer inside or outside the set
    for (int k = 1; k <= NPTR; k++) begin
      for (int ws = 0; ws < 2; ws++) begin
        int w, exp_mask, exp_cnt;
        w = (ws == 0) ? 1 : 9;
        do_reset();
        for (int i = 1; i <= k; i++) send(0, i);
        chk("R2 grants for fresh readers", n_msg[1], k);
        chk("R2 grant target", last_node, k);
        clear_log();
        exp_mask = ((1 << (k + 1)) - 2) & ~(1 << w);
        exp_cnt  = $countones(exp_mask);
        send(1, w);
        tick(NPTR + 2);
        chk("R5 inval set", inv_mask, exp_mask);
        chk("R5 inval count", inv_cnt, exp_cnt);
        chk("R6 no early grant", n_msg[4], (exp_cnt == 0) ? 1 : 0);
        for (int a = 0; a < exp_cnt; a++) begin
          if (a == exp_cnt - 1 && k == 3) begin
            send(0, 12);
            chk("R7 nack count", n_msg[3], 1);
            chk("R7 nack target", last_node, 12);
            send(1, 13);
            chk("R7 nack on write", n_msg[3], 2);
          end
          chk("R6 grant held before last ack", n_msg[4], 0);
          send(2, 0);
        end
        chk("R6 write grant", n_msg[4], 1);
        chk("R6 grant target", last_node, w);
        chk("R6 line_rw", line_rw, 1);
        chk("R6 meta normal", meta_state, 0);
        chk("R8 no error on counted acks", ack_err, 0);
      end
    end

    // R2 repeated reads take no extra pointer
    do_reset();
    send(0, 2); send(0, 2);
    chk("R2 repeat read grants", n_msg[1], 2);
    for (int i = 4; i <= 7; i++) send(0, i);
    chk("R2 five distinct fit", n_msg[5], 0);
    chk("R2 all granted", n_msg[1], 6);

    // R3/R4/R9 overflow path
    do_reset();
    for (int i = 1; i <= NPTR; i++) send(0, i);
    clear_log();
    send(0, 6);
    chk("R3 trap read", n_msg[5], 1);
    chk("R3 trap target", last_node, 6);
    chk("R3 no grant", n_msg[1], 0);
    chk("R4 meta transfer", meta_state, 1);
    chk("R4 ready low", req_ready, 0);
    tick(NPTR + 1);
    chk("R4 transfer set", xfer_mask, 32'h3E);
    chk("R4 transfer count", xfer_cnt, NPTR);
    chk("R4 meta trap-on-write", meta_state, 2);
    send(0, 7);
    chk("R4 read forwarded", n_msg[5], 2);
    chk("R4 read target", last_node, 7);
    chk("R4 still no grant", n_msg[1], 0);
    send(1, 3);
    chk("R9 trap write", n_msg[6], 1);
    chk("R9 trap write target", last_node, 3);
    tick(2);
    chk("R9 waits for vector", req_ready, 0);
    chk("R9 no inval yet", inv_cnt, 0);
    @(negedge clk); sw_vec = 16'h00FE; sw_vec_valid = 1'b1;
    @(negedge clk); sw_vec_valid = 1'b0;
    tick(8);
    chk("R9 inval set", inv_mask, 32'h00F6);
    chk("R9 inval count", inv_cnt, 6);
    send(0, 12);
    chk("R7 nack after software load", n_msg[3], 1);
    for (int a = 0; a < 6; a++) send(2, 0);
    chk("R9 write grant", n_msg[4], 1);
    chk("R9 grant target", last_node, 3);
    chk("R9 meta normal", meta_state, 0);
    chk("R9 line_rw", line_rw, 1);

    // R10 read by non-owner of a writable line
    clear_log();
    send(0, 5);
    tick(3);
    chk("R10 owner invalidated", inv_mask, 32'h8);
    chk("R10 no grant yet", n_msg[1], 0);
    send(2, 3);
    chk("R10 read grant", n_msg[1], 1);
    chk("R10 grant target", last_node, 5);
    chk("R10 line_rw clear", line_rw, 0);
    clear_log();
    send(1, 8);
    tick(3);
    chk("R10 reader sole sharer", inv_mask, 32'h20);
    send(2, 5);
    chk("R10 following write granted", n_msg[4], 1);

    // R8 stray acknowledgement
    do_reset();
    send(2, 4);
    chk("R8 flag set", ack_err, 1);
    chk("R8 no message", n_msg[1] + n_msg[2] + n_msg[3] + n_msg[4], 0);
    send(0, 1);
    chk("R8 read still granted", n_msg[1], 1);
    chk("R8 flag sticky", ack_err, 1);

    finish_run();
  end
endmodule